// File: doc/BRIEF.md
# Control-Transfer Next-PC Resolver

This combinational block picks the next program counter for a 32-bit integer core. It receives the address of the current instruction, the instruction word itself and the two source operand values read for it. From these it works out whether control leaves the sequential path. It decodes conditional branches, the direct jump-and-link and the register-indirect jump-and-link. It rebuilds the scattered offset fields of the branch and jump formats into signed offsets and forms the jump target.

The core uses these outputs in the same cycle. The next-PC value drives fetch. The link value and its write enable go to the register write port. A misalignment flag and an illegal-encoding flag go to the exception logic, which is not part of this block. Control transfers have no delay slot: the instruction at the target is the next one fetched.

Top module: `nxp_unit`

## Requirements
- R1: An opcode (instruction bits 6:0) other than 1100011, 1101111 or 1100111 gives next PC = PC+4, taken = 0, link enable = 0, misalign = 0 and illegal = 0.
- R2: With opcode 1100011, funct3 (bits 14:12) 000 is taken when the operands are equal and 001 is taken when they differ.
- R3: Branch funct3 100 is taken when operand A is less than operand B as two's-complement numbers, and 101 is taken when it is not less.
- R4: Branch funct3 110 is taken when A is below B as unsigned numbers, and 111 is taken when it is not below.
- R5: A taken branch goes to PC plus the sign-extended offset whose bit 12 is instr[31], bit 11 is instr[7], bits 10:5 are instr[30:25], bits 4:1 are instr[11:8] and bit 0 is zero. The offset ranges from -4096 to +4094.
- R6: Opcode 1101111 is always taken, whatever the operands. It goes to PC plus the sign-extended offset whose bit 20 is instr[31], bits 19:12 are instr[19:12], bit 11 is instr[20], bits 10:1 are instr[30:21] and bit 0 is zero.
- R7: Opcode 1100111 with funct3 000 is always taken. Its target is operand A plus the sign-extended instr[31:20], with bit 0 of the sum cleared.
- R8: The link value is always PC+4, wrapping at 2^32. The link enable is 1 only for the two jump kinds, and only when the rd field (bits 11:7) is not zero. Branches never raise it.
- R9: The misalign flag is 1 exactly when the transfer is taken and target bits 1:0 are not both zero. The next PC is still the target. A branch that is not taken never raises the flag.
- R10: Branch funct3 010 or 011 raises illegal. The branch is not taken and the next PC is PC+4.
- R11: Opcode 1100111 with a funct3 other than 000 raises illegal. It is not taken, gives next PC PC+4 and leaves the link enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| src_a_i | input | 32 | First source operand value |
| src_b_i | input | 32 | Second source operand value |
| next_pc_o | output | 32 | Address of the next instruction to fetch |
| taken_o | output | 1 | Control leaves the sequential path |
| link_val_o | output | 32 | Return address (PC+4) |
| link_we_o | output | 1 | Write the link value to rd |
| misalign_o | output | 1 | Taken target is not word aligned |
| illegal_o | output | 1 | Reserved branch or jump encoding |

## Verification
The bench builds the block with its defaults: a 32-bit data path and a word alignment rule (ALIGN_LG2 = 2). With word alignment, the halfword-granular branch and jump offsets and the cleared bit 0 of the register jump can all land on a target that raises the misalign flag. The full 32-bit width lets the extreme offsets and the PC+4 wrap be observed exactly. Instruction words are built in the bench from signed offsets, so each scrambled field position is checked, including the largest positive and most negative offsets.

// File: rtl/nxp_pkg.sv
package nxp_pkg;
  localparam int ILEN = 32;

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'b000,
    CMP_NE  = 3'b001,
    CMP_RSV0 = 3'b010,
    CMP_RSV1 = 3'b011,
    CMP_LT  = 3'b100,
    CMP_GE  = 3'b101,
    CMP_LTU = 3'b110,
    CMP_GEU = 3'b111
  } cmp_kind_e;

  // Conditional-branch offset, 13 significant bits, sign-extended to 32.
  function automatic logic [ILEN-1:0] br_offset(input logic [ILEN-1:0] w);
    logic [12:0] raw;
    raw = {w[31], w[7], w[30:25], w[11:8], 1'b0};
    return {{(ILEN-13){raw[12]}}, raw};
  endfunction

  // Direct-jump offset, 21 significant bits, sign-extended to 32.
  function automatic logic [ILEN-1:0] jmp_offset(input logic [ILEN-1:0] w);
    logic [20:0] raw;
    raw = {w[31], w[19:12], w[20], w[30:21], 1'b0};
    return {{(ILEN-21){raw[20]}}, raw};
  endfunction

  // Register-jump displacement, 12 significant bits, sign-extended to 32.
  function automatic logic [ILEN-1:0] reg_offset(input logic [ILEN-1:0] w);
    return {{(ILEN-12){w[31]}}, w[31:20]};
  endfunction
endpackage

// File: rtl/nxp_offsets.sv
module nxp_offsets
  import nxp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:0] instr,
  output logic [XLEN-1:0] br_off,
  output logic [XLEN-1:0] jmp_off,
  output logic [XLEN-1:0] reg_off
);
  assign br_off  = XLEN'(signed'(br_offset(instr)));
  assign jmp_off = XLEN'(signed'(jmp_offset(instr)));
  assign reg_off = XLEN'(signed'(reg_offset(instr)));
endmodule

// File: rtl/nxp_compare.sv
module nxp_compare
  import nxp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [2:0]      kind,
  output logic            hit,
  output logic            legal
);
  logic same, below_s, below_u;

  assign same    = (opa == opb);
  assign below_s = ($signed(opa) < $signed(opb));
  assign below_u = (opa < opb);

  always_comb begin
    hit   = 1'b0;
    legal = 1'b1;
    case (cmp_kind_e'(kind))
      CMP_EQ:  hit = same;
      CMP_NE:  hit = !same;
      CMP_LT:  hit = below_s;
      CMP_GE:  hit = !below_s;
      CMP_LTU: hit = below_u;
      CMP_GEU: hit = !below_u;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/nxp_unit.sv
module nxp_unit
  import nxp_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int ALIGN_LG2 = 2
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            link_we_o,
  output logic            misalign_o,
  output logic            illegal_o
);
  localparam logic [XLEN-1:0] STEP       = XLEN'(ILEN / 8);
  localparam logic [XLEN-1:0] ALIGN_MASK = (XLEN'(1) << ALIGN_LG2) - XLEN'(1);
  localparam logic [XLEN-1:0] LSB_CLEAR  = ~XLEN'(1);

  logic [6:0] opcode;
  logic [2:0] fn3;
  logic [4:0] rd;
  assign opcode = instr_i[6:0];
  assign fn3    = instr_i[14:12];
  assign rd     = instr_i[11:7];

  // named decode events
  logic is_branch, is_jal, is_jalr_op, jalr_ok;
  assign is_branch  = (opcode == OPC_BRANCH);
  assign is_jal     = (opcode == OPC_JAL);
  assign is_jalr_op = (opcode == OPC_JALR);
  assign jalr_ok    = is_jalr_op && (fn3 == 3'b000);

  logic [XLEN-1:0] br_off, jmp_off, reg_off;
  nxp_offsets #(.XLEN(XLEN)) u_off (
    .instr   (instr_i),
    .br_off  (br_off),
    .jmp_off (jmp_off),
    .reg_off (reg_off)
  );

  logic cond_hit, cond_legal;
  nxp_compare #(.XLEN(XLEN)) u_cmp (
    .opa   (src_a_i),
    .opb   (src_b_i),
    .kind  (fn3),
    .hit   (cond_hit),
    .legal (cond_legal)
  );

  logic [XLEN-1:0] seq_pc, target;
  logic            br_taken;
  assign seq_pc   = pc_i + STEP;
  assign br_taken = is_branch && cond_legal && cond_hit;

  always_comb begin
    if (is_jal)
      target = pc_i + jmp_off;
    else if (is_jalr_op)
      target = (src_a_i + reg_off) & LSB_CLEAR;
    else
      target = pc_i + br_off;
  end

  assign taken_o    = br_taken || is_jal || jalr_ok;
  assign next_pc_o  = taken_o ? target : seq_pc;
  assign link_val_o = seq_pc;
  assign link_we_o  = (is_jal || jalr_ok) && (rd != 5'd0);
  assign misalign_o = taken_o && ((target & ALIGN_MASK) != '0);
  assign illegal_o  = (is_branch && !cond_legal) || (is_jalr_op && !jalr_ok);
endmodule

// File: rtl/nxp_unit_chk.sv
module nxp_unit_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic            misalign_o,
  input logic            illegal_o,
  input logic            is_jal,
  input logic            jalr_ok,
  input logic            is_branch,
  input logic [4:0]      rd
);
  always_comb begin
    // R1
    if (!taken_o) seq_path_chk: assert (next_pc_o == pc_i + XLEN'(4)) else $error("seq path");
    // R6
    if (is_jal) jal_taken_chk: assert (taken_o) else $error("jal not taken");
    // R7
    if (jalr_ok) jalr_lsb_chk: assert (next_pc_o[0] == 1'b0) else $error("jalr lsb");
    // R8
    if (link_we_o) link_src_chk: assert ((is_jal || jalr_ok) && rd != 5'd0 && !is_branch) else $error("link we");
    // R9
    if (misalign_o) mis_taken_chk: assert (taken_o) else $error("misalign untaken");
    // R10
    if (illegal_o) ill_block_chk: assert (!taken_o && !link_we_o) else $error("illegal taken");
  end
endmodule

bind nxp_unit nxp_unit_chk #(.XLEN(XLEN)) u_chk (
  .pc_i       (pc_i),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .link_we_o  (link_we_o),
  .misalign_o (misalign_o),
  .illegal_o  (illegal_o),
  .is_jal     (is_jal),
  .jalr_ok    (jalr_ok),
  .is_branch  (is_branch),
  .rd         (rd)
);

// File: tb/nxp_unit_test.sv
module nxp_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pc, instr, a, b, next_pc, link_val;
  logic taken, link_we, mis, ill;
  int total = 0, bad = 0;

  nxp_unit uut (
    .pc_i(pc), .instr_i(instr), .src_a_i(a), .src_b_i(b),
    .next_pc_o(next_pc), .taken_o(taken), .link_val_o(link_val),
    .link_we_o(link_we), .misalign_o(mis), .illegal_o(ill)
  );

  function automatic logic [31:0] mk_br(input logic [31:0] off, input logic [2:0] f3);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] mk_jal(input logic [31:0] off, input logic [4:0] r);
    return {off[20], off[10:1], off[11], off[19:12], r, 7'b1101111};
  endfunction
  function automatic logic [31:0] mk_jalr(input logic [31:0] off, input logic [4:0] r, input logic [2:0] f3);
    return {off[11:0], 5'd1, f3, r, 7'b1100111};
  endfunction

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  kind;   // 0 branch, 1 jal, 2 jalr, 3 raw word in off
    logic [2:0]  f3;
    logic [4:0]  rd;
    logic [31:0] off, pc, a, b, enext;
    logic        etk, ewe, emis, eill;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 2'd0, 3'b000, 5'd0, 32'd16,        32'h1000, 32'd5,        32'd5,        32'h1010, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 eq hit
    '{4'd2, 2'd0, 3'b000, 5'd0, 32'd16,        32'h1000, 32'd5,        32'd6,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 eq miss
    '{4'd2, 2'd0, 3'b001, 5'd0, 32'hFFFFFFF8,  32'h1000, 32'd1,        32'd2,        32'h0FF8, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 ne back
    '{4'd3, 2'd0, 3'b100, 5'd0, 32'd32,        32'h1000, 32'hFFFFFFFF, 32'd1,        32'h1020, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 signed lt
    '{4'd4, 2'd0, 3'b110, 5'd0, 32'd32,        32'h1000, 32'hFFFFFFFF, 32'd1,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 unsigned lt
    '{4'd3, 2'd0, 3'b101, 5'd0, 32'd8,         32'h1000, 32'd1,        32'hFFFFFFFF, 32'h1008, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 signed ge
    '{4'd4, 2'd0, 3'b111, 5'd0, 32'd8,         32'h1000, 32'hFFFFFFFF, 32'd1,        32'h1008, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 unsigned ge
    '{4'd4, 2'd0, 3'b111, 5'd0, 32'd8,         32'h1000, 32'd1,        32'd2,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 ge miss
    '{4'd5, 2'd0, 3'b000, 5'd0, 32'd4094,      32'h1000, 32'd7,        32'd7,        32'h1FFE, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 max, R9
    '{4'd5, 2'd0, 3'b000, 5'd0, 32'hFFFFF000,  32'h1000, 32'd7,        32'd7,        32'h0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 min
    '{4'd6, 2'd1, 3'b000, 5'd1, 32'h000FFFFE,  32'h00100000, 32'd0,    32'd0,        32'h001FFFFE, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 max
    '{4'd6, 2'd1, 3'b000, 5'd0, 32'hFFF00000,  32'h00100000, 32'd0,    32'd0,        32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 min, R8 rd0
    '{4'd6, 2'd1, 3'b000, 5'd5, 32'h00055554,  32'h0,    32'd0,        32'd0,        32'h00055554, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 pattern
    '{4'd7, 2'd2, 3'b000, 5'd1, 32'd2,         32'h1000, 32'h2003,     32'd0,        32'h2004, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 lsb clear
    '{4'd7, 2'd2, 3'b000, 5'd1, 32'hFFFFFFFF,  32'h1000, 32'h3000,     32'd0,        32'h2FFE, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 neg, R9
    '{4'd11,2'd2, 3'b010, 5'd1, 32'd4,         32'h1000, 32'h3000,     32'd0,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b1}, // R11
    '{4'd10,2'd0, 3'b010, 5'd0, 32'd16,        32'h1000, 32'd5,        32'd5,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 010
    '{4'd10,2'd0, 3'b011, 5'd0, 32'd16,        32'h1000, 32'd5,        32'd9,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 011
    '{4'd1, 2'd3, 3'b000, 5'd0, 32'h00508193,  32'h1000, 32'd5,        32'd5,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 alu imm
    '{4'd1, 2'd3, 3'b000, 5'd0, 32'h123452B7,  32'h1000, 32'd5,        32'd5,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 upper imm
    '{4'd9, 2'd0, 3'b001, 5'd0, 32'd2,         32'h1000, 32'd4,        32'd4,        32'h1004, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 untaken odd
    '{4'd8, 2'd2, 3'b000, 5'd0, 32'd8,         32'h1000, 32'h4000,     32'd0,        32'h4008, 1'b1, 1'b0, 1'b0, 1'b0}  // R8 jalr rd0
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] w, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    pc = p; instr = w; a = x; b = y;
    #5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pc = 32'h0; instr = 32'h0; a = 32'h0; b = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #5;
    // R1: idle state with an all-zero word
    chk("R1", "reset next", next_pc, 32'h4);
    chk("R1", "reset flags", {28'd0, taken, link_we, mis, ill}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      string tag;
      vec_t v;
      v = VECS[i];
      case (v.kind)
        2'd0:    w = mk_br(v.off, v.f3);
        2'd1:    w = mk_jal(v.off, v.rd);
        2'd2:    w = mk_jalr(v.off, v.rd, v.f3);
        default: w = v.off;
      endcase
      apply(v.pc, w, v.a, v.b);
      tag = $sformatf("R%0d row%0d", v.req, i);
      chk(tag, "next", next_pc, v.enext);
      chk(tag, "flags", {28'd0, taken, link_we, mis, ill}, {28'd0, v.etk, v.ewe, v.emis, v.eill});
      chk(tag, "link", link_val, v.pc + 32'd4);
    end

    // R8: link value wraps at the top of the address space
    apply(32'hFFFFFFFC, mk_jal(32'd8, 5'd1), 32'd0, 32'd0);
    chk("R8", "link wrap", link_val, 32'h0);
    chk("R6", "jal wrap target", next_pc, 32'h4);

    // R6: operand values have no effect on a direct jump
    apply(32'h2000, mk_jal(32'h100, 5'd3), 32'hDEADBEEF, 32'h12345678);
    chk("R6", "jal ignores operands", next_pc, 32'h2100);

    // R5: branch offset bit 11 lands correctly (+2048)
    apply(32'h4000, mk_br(32'd2048, 3'b000), 32'd1, 32'd1);
    chk("R5", "bit11 offset", next_pc, 32'h4800);

    // R9: taken branch to halfword boundary
    apply(32'h4000, mk_br(32'd6, 3'b001), 32'd1, 32'd2);
    chk("R9", "halfword target", {31'd0, mis}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule